// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block is the external-bus side of an on-chip master. It takes one internal access (address, direction, operand size and right-justified write data) and turns it into the sequence of external bus beats that the addressed port can carry. Each request brings its own port setting of 8, 16 or 32 bits, a wait-state count, a choice between ending each beat on an internal counter or on an external acknowledge, and a burst flag. Narrow ports sit on the upper byte lanes of the 32-bit data bus. An operand wider than the port is split into consecutive beats, most significant part first, and the address advances by the port width on each beat.

Address, write data, transfer start, direction and size code change on the rising clock edge. The address strobe, chip select, output enable and byte enables change on the falling edge. Read data is sampled on the rising edge that ends each beat. The parts are packed into one right-justified result that appears with a one-cycle done pulse when the last beat ends.

Top module: `dyn_size_master`

## Requirements
- R1: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the edge that ends the last beat. A request presented while the master is busy has no effect.
- R2: Size codes on `req_size` and `bus_siz` are 01 byte, 10 word and 00 longword. Request code 11 is handled as a longword. Port codes on `cfg_port` are 01 for 8-bit, 10 for 16-bit and 00 for 32-bit, with 11 handled as 32-bit. The number of beats is the operand width divided by the port width when the operand is wider, and one otherwise.
- R3: Beat k (counting from 0) drives `bus_addr` equal to the request address plus k times the port width in bytes. The address holds for the whole beat.
- R4: `bus_ts` is high for exactly one cycle, the first cycle of each beat.
- R5: With internal termination (`cfg_ext_ack`=0), every beat lasts `cfg_waits`+1 cycles and `bus_ta` is ignored.
- R6: With external termination (`cfg_ext_ack`=1), a beat ends at the first rising edge where `bus_ta` is high, and `cfg_waits` is ignored.
- R7: The first beat carries the operand size code. Later beats carry the operand code when `cfg_burst`=1, and the port code (01 for 8-bit, 10 for 16-bit) when `cfg_burst`=0.
- R8: Byte-enable bit 3 covers D[31:24], bit 2 D[23:16], bit 1 D[15:8] and bit 0 D[7:0]. Each beat carries min(operand, port) bytes. The start lane is D[31:24] plus the beat address modulo the port width. On writes, `bus_dout` carries the operand bytes for that beat on those lanes, most significant byte on the highest lane.
- R9: On reads, the bytes taken from the enabled lanes of every beat are joined in bus order. The first byte ends up most significant, and the result is right-justified in `rsp_rdata`.
- R10: `rsp_done` is high for one cycle, the cycle after the edge that ends the last beat, and `req_ready` is high in that same cycle. `rsp_rdata` holds its value until the next transfer ends.
- R11: While busy, `bus_as` and `bus_cs` are high and `bus_oe` is high only for reads, all updated on falling edges. When idle they are low and `bus_be` is 0000. `bus_rnw` is 1 for reads and 0 for writes.
- R12: After reset `req_ready` is 1, and `bus_ts`, `rsp_done`, `bus_as`, `bus_cs`, `bus_oe` and `bus_be` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Operand size code |
| req_wdata | input | 32 | Right-justified write operand |
| cfg_port | input | 2 | Port width code |
| cfg_waits | input | WAIT_W | Wait cycles per beat for internal termination |
| cfg_ext_ack | input | 1 | 1: beats end on bus_ta |
| cfg_burst | input | 1 | 1: size code keeps operand size on all beats |
| rsp_done | output | 1 | One-cycle pulse after the last beat |
| rsp_rdata | output | 32 | Right-justified read result |
| bus_addr | output | ADDR_W | Beat address |
| bus_dout | output | 32 | Write data lanes |
| bus_dout_en | output | 1 | Write data is being driven |
| bus_din | input | 32 | Read data lanes |
| bus_ts | output | 1 | Transfer start |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_rnw | output | 1 | 1 read, 0 write |
| bus_siz | output | 2 | Size code of the beat |
| bus_as | output | 1 | Address strobe (falling edge) |
| bus_cs | output | 1 | Chip select (falling edge) |
| bus_oe | output | 1 | Output enable (falling edge) |
| bus_be | output | 4 | Byte enables (falling edge) |

## Verification
The embedded assertions watch, on every cycle, that ready stays low through a transfer, that transfer start never repeats inside a beat, and that the address holds within a beat and steps by the port width between beats. They also check that the wait counter stays inside its window under internal termination, that the first beat shows the operand size, that done is a single pulse seen while idle, and that the read result changes only when a beat ends. Only the bench's scenarios can show that the beat count, lane placement, write bytes, packed read result and beat lengths match what each combination of size, port, offset, burst setting and termination mode should give. The same holds for ignoring a request made while busy and for ignoring the unused one of `cfg_waits` and `bus_ta`.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  localparam logic [1:0] CODE_LONG = 2'b00;
  localparam logic [1:0] CODE_BYTE = 2'b01;
  localparam logic [1:0] CODE_WORD = 2'b10;

  // Request code 11 (line) is carried as a longword.
  function automatic logic [1:0] norm_size(input logic [1:0] code);
    return (code == 2'b11) ? CODE_LONG : code;
  endfunction

  // Bytes for a size or port code; 00 and 11 mean four bytes.
  function automatic int unsigned code_bytes(input logic [1:0] code);
    case (code)
      CODE_BYTE: return 1;
      CODE_WORD: return 2;
      default:   return 4;
    endcase
  endfunction

  function automatic int unsigned beat_count(input int unsigned ob, input int unsigned pb);
    return (ob > pb) ? (ob / pb) : 1;
  endfunction

  function automatic int unsigned chunk_bytes(input int unsigned ob, input int unsigned pb);
    return (ob < pb) ? ob : pb;
  endfunction

  // Enables: top cb lanes, moved down by the lane offset. Bit 3 is D[31:24].
  function automatic logic [3:0] lane_mask(input int unsigned cb, input int unsigned off);
    logic [7:0] wide;
    logic [3:0] top;
    wide = 8'hF0 >> cb;
    top  = wide[3:0];
    return top >> off;
  endfunction

  // Picks beat k of a right-justified operand and places it on the lanes.
  function automatic logic [DATA_W-1:0] place_write(input logic [DATA_W-1:0] wd,
                                                     input int unsigned nb, input int unsigned k,
                                                     input int unsigned cb, input int unsigned off);
    logic [2*DATA_W-1:0] t;
    logic [2*DATA_W-1:0] keep;
    t    = {{DATA_W{1'b0}}, wd} >> (8 * cb * (nb - 1 - k));
    keep = ({{(2*DATA_W-1){1'b0}}, 1'b1} << (8 * cb)) - 1;
    t    = (t & keep) << (DATA_W - 8 * cb);
    t    = t >> (8 * off);
    return t[DATA_W-1:0];
  endfunction

  // Extracts the cb enabled bytes of a beat as a right-justified value.
  function automatic logic [DATA_W-1:0] pull_read(input logic [DATA_W-1:0] din,
                                                   input int unsigned cb, input int unsigned off);
    logic [2*DATA_W-1:0] t;
    t = {{DATA_W{1'b0}}, din} << (8 * off);
    t = t & {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
    t = t >> (DATA_W - 8 * cb);
    return t[DATA_W-1:0];
  endfunction

endpackage

// File: rtl/dbs_beat_timer.sv
module dbs_beat_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic              use_ext,
  input  logic [WAIT_W-1:0] waits,
  input  logic              ta,
  output logic              first_cyc,
  output logic              beat_end
);

  localparam logic [WAIT_W-1:0] CNT_MAX = '1;

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= CNT_MAX;
    else if (restart)      cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign first_cyc = active && (cnt == '0);
  assign beat_end  = active && (use_ext ? ta : (cnt == waits));

  // R4: a beat that keeps running never shows transfer start again
  p_ts_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active && !beat_end |=> !first_cyc);

  // R5: internal termination never lets the counter pass the wait count
  p_wait_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active && !use_ext |-> cnt <= waits);

endmodule

// File: rtl/dbs_lane_steer.sv
module dbs_lane_steer
  import dbs_pkg::*;
(
  input  logic [2:0]        beats,
  input  logic [2:0]        chunk,
  input  logic [1:0]        beat,
  input  logic [1:0]        lane_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] rchunk
);

  always_comb begin
    dout   = place_write(wdata, 32'(beats), 32'(beat), 32'(chunk), 32'(lane_off));
    be     = lane_mask(32'(chunk), 32'(lane_off));
    rchunk = pull_read(din, 32'(chunk), 32'(lane_off));
  end

endmodule

// File: rtl/dbs_read_pack.sv
module dbs_read_pack
  import dbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              last,
  input  logic [2:0]        chunk,
  input  logic [DATA_W-1:0] part,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] acc_next;

  always_comb acc_next = (acc << (8 * 32'(chunk))) | part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= capture && last;
      if (clear)        acc <= '0;
      else if (capture) acc <= acc_next;
      if (capture && last) rdata <= acc_next;
    end
  end

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the result only moves when the final beat ends
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && last) |=> $stable(rdata));

endmodule

// File: rtl/dyn_size_master.sv
module dyn_size_master
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cfg_port,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              cfg_ext_ack,
  input  logic              cfg_burst,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_ts,
  input  logic              bus_ta,
  output logic              bus_rnw,
  output logic [1:0]        bus_siz,
  output logic              bus_as,
  output logic              bus_cs,
  output logic              bus_oe,
  output logic [LANES-1:0]  bus_be
);

  // Latched request
  logic              busy;
  logic [1:0]        beat_idx;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_write;
  logic [1:0]        lat_size;
  logic [1:0]        lat_port;
  logic [WAIT_W-1:0] lat_waits;
  logic              lat_ext;
  logic              lat_burst;
  logic [DATA_W-1:0] lat_wdata;

  // Named events
  logic accept, beat_end, last, restart, first_cyc;

  // Beat geometry
  int unsigned       ob, pb;
  logic [2:0]        nb_w, cb_w;
  logic [1:0]        off_w;
  logic [ADDR_W-1:0] addr_k, port_step;
  logic [DATA_W-1:0] lane_dout, lane_part;
  logic [LANES-1:0]  lane_be;

  always_comb begin
    ob        = code_bytes(lat_size);
    pb        = code_bytes(lat_port);
    nb_w      = 3'(beat_count(ob, pb));
    cb_w      = 3'(chunk_bytes(ob, pb));
    port_step = ADDR_W'(pb);
    addr_k    = lat_addr + ADDR_W'(32'(beat_idx) * pb);
    off_w     = addr_k[1:0] & 2'(pb - 1);
  end

  assign accept  = req_valid && !busy;
  assign last    = ({1'b0, beat_idx} == nb_w - 3'd1);
  assign restart = accept || (beat_end && !last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      beat_idx  <= '0;
      lat_addr  <= '0;
      lat_write <= 1'b0;
      lat_size  <= CODE_LONG;
      lat_port  <= CODE_LONG;
      lat_waits <= '0;
      lat_ext   <= 1'b0;
      lat_burst <= 1'b0;
      lat_wdata <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      beat_idx  <= '0;
      lat_addr  <= req_addr;
      lat_write <= req_write;
      lat_size  <= norm_size(req_size);
      lat_port  <= cfg_port;
      lat_waits <= cfg_waits;
      lat_ext   <= cfg_ext_ack;
      lat_burst <= cfg_burst;
      lat_wdata <= req_wdata;
    end else if (beat_end) begin
      if (last) busy     <= 1'b0;
      else      beat_idx <= beat_idx + 2'd1;
    end
  end

  dbs_beat_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (busy),
    .restart   (restart),
    .use_ext   (lat_ext),
    .waits     (lat_waits),
    .ta        (bus_ta),
    .first_cyc (first_cyc),
    .beat_end  (beat_end)
  );

  dbs_lane_steer u_steer (
    .beats    (nb_w),
    .chunk    (cb_w),
    .beat     (beat_idx),
    .lane_off (off_w),
    .wdata    (lat_wdata),
    .din      (bus_din),
    .dout     (lane_dout),
    .be       (lane_be),
    .rchunk   (lane_part)
  );

  dbs_read_pack u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (beat_end),
    .last    (last),
    .chunk   (cb_w),
    .part    (lane_part),
    .rdata   (rsp_rdata),
    .done    (rsp_done)
  );

  // Rising-edge side
  assign req_ready   = !busy;
  assign bus_ts      = first_cyc;
  assign bus_addr    = busy ? addr_k : lat_addr;
  assign bus_rnw     = busy ? !lat_write : 1'b1;
  assign bus_dout    = lane_dout;
  assign bus_dout_en = busy && lat_write;
  assign bus_siz     = (beat_idx == 2'd0 || lat_burst) ? lat_size : lat_port;

  // Falling-edge side
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_as <= 1'b0;
      bus_cs <= 1'b0;
      bus_oe <= 1'b0;
      bus_be <= '0;
    end else begin
      bus_as <= busy;
      bus_cs <= busy;
      bus_oe <= busy && !lat_write;
      bus_be <= busy ? lane_be : '0;
    end
  end

  // R1: taking a request drops ready on the next cycle
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R1: ready stays low until the final beat ends
  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !(beat_end && last) |=> !req_ready);

  // R3: address holds inside a beat
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !beat_end |=> $stable(bus_addr));

  // R3: address steps by the port width between beats
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && beat_end && !last |=> bus_addr - $past(bus_addr) == port_step);

  // R7: first beat reports the operand size
  p_siz_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_siz == $past(norm_size(req_size)));

  // R10: done only appears while idle and without a new start
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready && !bus_ts);

  // R8: no beat enables three lanes
  p_be_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_be) != 3);

endmodule

// File: tb/dyn_size_master_test.sv
module dyn_size_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  cfg_port = '0;
  logic [3:0]  cfg_waits = '0;
  logic        cfg_ext_ack = 1'b0;
  logic        cfg_burst = 1'b0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [31:0] bus_addr;
  logic [31:0] bus_dout;
  logic        bus_dout_en;
  logic [31:0] bus_din;
  logic        bus_ts;
  logic        bus_ta = 1'b0;
  logic        bus_rnw;
  logic [1:0]  bus_siz;
  logic        bus_as, bus_cs, bus_oe;
  logic [3:0]  bus_be;

  int errors = 0;
  int checks = 0;
  logic [1:0] cur_port = 2'b00;

  always #2 clk = ~clk;

  dyn_size_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .cfg_port(cfg_port), .cfg_waits(cfg_waits),
    .cfg_ext_ack(cfg_ext_ack), .cfg_burst(cfg_burst), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_ts(bus_ts),
    .bus_ta(bus_ta), .bus_rnw(bus_rnw), .bus_siz(bus_siz), .bus_as(bus_as),
    .bus_cs(bus_cs), .bus_oe(bus_oe), .bus_be(bus_be)
  );

  // Bench-side memory: each byte is a pattern of its address.
  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic int width_of(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 4;
  endfunction

  // The slave serves its own lanes, junk on the unused ones.
  function automatic logic [31:0] serve(input logic [31:0] a, input logic [1:0] pc);
    logic [31:0] v;
    int w;
    w = width_of(pc);
    v = 32'hEEEEEEEE;
    for (int l = 0; l < w; l++)
      v[31-8*l -: 8] = mem_byte((a & ~(32'(w) - 1)) + 32'(l));
    return v;
  endfunction

  assign bus_din = serve(bus_addr, cur_port);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic [1:0]  port;
    logic [31:0] addr;
    logic        wr;
    logic [31:0] wd;
    logic [3:0]  waits;
    logic        ext;
    logic        burst;
    logic [3:0]  ackdly;
    logic        noise;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b00, 32'h0000_0100, 1'b0, 32'h0,         4'd0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'b00, 2'b01, 32'h0000_0200, 1'b0, 32'h0,         4'd1, 1'b0, 1'b0, 4'd0, 1'b1},
    '{2'b00, 2'b10, 32'h0000_0304, 1'b0, 32'h0,         4'd0, 1'b0, 1'b1, 4'd0, 1'b0},
    '{2'b00, 2'b01, 32'h0000_0040, 1'b1, 32'h1122_3344, 4'd0, 1'b0, 1'b1, 4'd0, 1'b0},
    '{2'b00, 2'b10, 32'h0000_0080, 1'b1, 32'hA1B2_C3D4, 4'd2, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'b10, 2'b01, 32'h0000_0012, 1'b0, 32'h0,         4'd0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'b10, 2'b00, 32'h0000_0022, 1'b1, 32'h0000_BEEF, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'b01, 2'b00, 32'h0000_0033, 1'b0, 32'h0,         4'd0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'b01, 2'b10, 32'h0000_0045, 1'b1, 32'h0000_007E, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'b00, 2'b10, 32'h0000_0410, 1'b0, 32'h0,         4'd7, 1'b1, 1'b0, 4'd3, 1'b0},
    '{2'b10, 2'b01, 32'h0000_0056, 1'b1, 32'h0000_C0DE, 4'd5, 1'b1, 1'b0, 4'd0, 1'b0},
    '{2'b01, 2'b10, 32'h0000_0044, 1'b0, 32'h0,         4'd0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{2'b11, 2'b11, 32'h0000_0500, 1'b0, 32'h0,         4'd1, 1'b0, 1'b0, 4'd0, 1'b0}
  };

  task automatic run_vec(input vec_t v, input bit junk);
    int n, w, nbeats, cb, dur, k, cyc, busy_cyc, guard, off;
    logic [31:0] exp_addr, exp_rd;
    logic [3:0]  exp_be;
    logic [1:0]  exp_siz, op_code;
    bit seen_done;
    op_code = (v.sz == 2'b11) ? 2'b00 : v.sz;
    n      = width_of(op_code);
    w      = width_of(v.port);
    nbeats = (n > w) ? n / w : 1;
    cb     = (n > w) ? w : n;
    dur    = v.ext ? int'(v.ackdly) + 1 : int'(v.waits) + 1;
    exp_rd = '0;
    for (int j = 0; j < n; j++) exp_rd = (exp_rd << 8) | 32'(mem_byte(v.addr + 32'(j)));

    req_addr = v.addr; req_write = v.wr; req_size = v.sz; req_wdata = v.wd;
    cfg_port = v.port; cfg_waits = v.waits; cfg_ext_ack = v.ext; cfg_burst = v.burst;
    cur_port = v.port;
    req_valid = 1'b1;
    @(posedge clk); #1;
    if (junk) begin req_addr = 32'hDEAD_0000; req_size = 2'b01; end
    else req_valid = 1'b0;
    #2;
    k = -1; cyc = 0; busy_cyc = 0; guard = 0; seen_done = 0;
    while (!seen_done && guard < 300) begin
      guard++;
      if (rsp_done) begin
        seen_done = 1;
        req_valid = 1'b0;
        bus_ta = 1'b0;
        check(req_ready, "R10 ready with done", 32'(req_ready), 32'd1);
        check(!bus_as && !bus_cs && bus_be == 4'b0, "R11 strobes off when idle",
              {bus_as, bus_cs, bus_be}, 32'd0);
        if (!v.wr) check(rsp_rdata == exp_rd, "R9 read result", rsp_rdata, exp_rd);
      end else begin
        if (!req_ready) busy_cyc++;
        if (bus_ts) begin
          k++; cyc = 0;
          exp_addr = v.addr + 32'(k * w);
          check(bus_addr == exp_addr, "R3 beat address", bus_addr, exp_addr);
          exp_siz = (k == 0 || v.burst) ? op_code : v.port;
          check(bus_siz == exp_siz, "R7 size code", 32'(bus_siz), 32'(exp_siz));
          off = int'(exp_addr[1:0]) % w;
          exp_be = '0;
          for (int l = 0; l < 4; l++) if (l >= off && l < off + cb) exp_be[3-l] = 1'b1;
          check(bus_be == exp_be, "R8 byte enables", 32'(bus_be), 32'(exp_be));
          if (v.wr) begin
            for (int l = off; l < off + cb; l++) begin
              int j;
              logic [7:0] eb;
              j  = k * cb + (l - off);
              eb = v.wd[8*(n-1-j) +: 8];
              check(bus_dout[31-8*l -: 8] == eb && bus_dout_en, "R8 write lane",
                    32'(bus_dout[31-8*l -: 8]), 32'(eb));
            end
          end
        end else cyc++;
        check(bus_as && bus_cs && bus_oe == !v.wr && bus_rnw == !v.wr, "R11 busy strobes",
              {bus_as, bus_cs, bus_oe, bus_rnw}, {1'b1, 1'b1, !v.wr, !v.wr});
        bus_ta = v.noise ? 1'b1 : (v.ext && cyc == int'(v.ackdly));
      end
      if (!seen_done) begin @(posedge clk); #3; end
    end
    bus_ta = 1'b0;
    check(seen_done, "R10 done seen", 32'(seen_done), 32'd1);
    check(k + 1 == nbeats, "R2 beat count", 32'(k + 1), 32'(nbeats));
    check(busy_cyc == nbeats * dur, v.ext ? "R6 ack-timed length" : "R5 wait-timed length",
          32'(busy_cyc), 32'(nbeats * dur));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #3;
    // R12 reset state
    check(req_ready && !bus_ts && !rsp_done, "R12 reset handshake",
          {req_ready, bus_ts, rsp_done}, 32'b100);
    check(!bus_as && !bus_cs && !bus_oe && bus_be == 4'b0, "R12 reset strobes",
          {bus_as, bus_cs, bus_oe, bus_be}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], 1'b0);
      @(posedge clk); #3;
    end

    // R10: done single cycle, result held afterwards
    run_vec(VECS[0], 1'b0);
    held = rsp_rdata;
    @(posedge clk); #3;
    check(!rsp_done, "R10 done one cycle", 32'(rsp_done), 32'd0);
    repeat (2) @(posedge clk);
    #3 check(rsp_rdata == held, "R10 result held", rsp_rdata, held);

    // R1: request held high while busy is ignored
    run_vec(VECS[1], 1'b1);
    repeat (3) begin
      @(posedge clk); #3;
      check(!bus_ts && req_ready, "R1 no extra transfer", {bus_ts, req_ready}, 32'b01);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule